// File: doc/BRIEF.md
# Serial Command Frame Transmitter

This block is the transmit half of a two-wire serial master, with one clock wire and one bidirectional data wire, that reaches the register space of slaves on the link. A request names a slave, the frame kind, and for a register access the direction, address, access size and write data. The block assembles the frame and computes a 4-bit CRC over it while it is shifted out. It drives the bits on an active-low data line, one bit per serial clock period.

After the last CRC bit the block drives the line idle for a fixed number of clock periods, the echo delay. It then stops the serial clock, releases the data line to the response receiver and pulses `done`. Besides register accesses it builds the short poll frame and the terminate frame.

The FSM has four states. `ST_IDLE` has the clock parked high and the line released. `ST_FRAME` shifts the start bit and the frame bits. `ST_CRC` shifts the four check bits. `ST_ECHO` drives idle bits for the echo delay. The transitions are:
- IDLE to FRAME on an accepted request.
- FRAME to CRC at the end of the last frame bit.
- CRC to ECHO at the end of the fourth check bit.
- ECHO to IDLE at the end of the last echo slot, where `done` is raised.

Top module: `cmdframe_tx`

## Requirements
- R1: `req_ready` is high only in `ST_IDLE`. A request is taken at a rising `clk` edge where `req_valid` and `req_ready` are both high. `done` is high for exactly one cycle: the first idle cycle after the echo delay, in which `req_ready` is also high.
- R2: The data line is active low. A logical 1 is driven as `sdo`=0, and a logical 0 or an idle bit is driven as `sdo`=1. Whenever the line is released (`sdo_oe`=0), `sdo` rests at 1.
- R3: Each serial bit slot lasts 2*CLK_DIV `clk` cycles, with `sclk` low for the first CLK_DIV cycles and high for the rest. `sdo` changes only when a slot begins, so it is stable while `sclk` is high. In idle, `sclk` is held high. The first slot begins in the cycle right after the request is taken.
- R4: Every frame opens with a start bit of logical 1, followed by the frame bits, most significant bit first.
- R5: `req_kind`=0 sends an access frame. Its fields, in order, are the 2-bit `req_id`, the code 100, one direction bit (1 = read, i.e. `req_write`=0), the 21-bit address, one size bit, and then the write data.
- R6: `req_size` 0 selects 1 byte: the address is sent unchanged with size bit 0. Size 1 selects 2 bytes: address bit 0 is cleared and the size bit is 1. Sizes 2 and 3 select 4 bytes: address bits 1:0 are sent as 01 and the size bit is 1.
- R7: A write sends 1, 2 or 4 data bytes after the size bit. Byte k is `req_wdata[8k+7:8k]`, byte 0 goes first, and each byte is sent MSB first. A read sends no data bytes.
- R8: `req_kind`=1 sends a poll frame: `req_id` followed by the code 010.
- R9: `req_kind` 2 and 3 both send a terminate frame: `req_id` followed by the code 111111.
- R10: The CRC uses x^4+x+1 with an all-zero start value. It covers the start bit and every frame bit and is sent after the last frame bit, CRC bit 3 first.
- R11: After the CRC, ECHO_SLOTS (16) bit slots are driven idle (`sdo`=1, `sdo_oe`=1). `sdo_oe` is high from the start bit through the last echo slot and low otherwise.
- R12: During reset, `sclk`=1, `sdo`=1, `sdo_oe`=0, `done`=0 and `req_ready`=1.
- R13: While a frame is in progress, `req_ready` is low, and `req_valid` together with any request field has no effect on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The block can take a request |
| req_kind | input | 2 | 0 access, 1 poll, 2 or 3 terminate |
| req_id | input | 2 | Slave identifier |
| req_write | input | 1 | 1 write, 0 read (access frames) |
| req_addr | input | 21 | Register address |
| req_size | input | 2 | 0 one byte, 1 two bytes, 2 or 3 four bytes |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data level (active low) |
| sdo_oe | output | 1 | High while the master drives the data wire |
| done | output | 1 | One-cycle pulse at the end of the echo delay |

## Verification
Once a request is taken at an edge, the start bit's level and the falling `sclk` appear in the very next cycle. Each following bit, including the CRC and echo bits, appears 2*CLK_DIV cycles after the one before it. `done` rises (frame bits + 5 + 16) * 2*CLK_DIV cycles after the accepting edge. The bench model counts cycles from the accepting edge and derives the slot number and clock phase from that count. It compares every output at the falling `clk` edge, half a cycle after the registers have settled. Each expected line bit carries the tag of the field it belongs to, so a mismatch reports which part of the frame went wrong.

// File: rtl/cft_pkg.sv
package cft_pkg;

    localparam int ID_W       = 2;
    localparam int ADDR_W     = 21;
    localparam int DATA_BYTES = 4;
    localparam int DATA_W     = DATA_BYTES * 8;
    localparam int CRC_W      = 4;
    localparam int OPC_W      = 3;
    localparam int TOPC_W     = 6;
    // start + id + opcode + direction + address + size bit
    localparam int HDR_LEN    = 1 + ID_W + OPC_W + 1 + ADDR_W + 1;
    localparam int FRAME_W    = HDR_LEN + DATA_W;
    localparam int LEN_W      = $clog2(FRAME_W + 1);

    localparam logic [OPC_W-1:0]  OPC_ACCESS = 3'b100;
    localparam logic [OPC_W-1:0]  OPC_POLL   = 3'b010;
    localparam logic [TOPC_W-1:0] OPC_TERM   = 6'b111111;
    localparam logic [CRC_W-1:0]  CRC_POLY   = 4'b0011;

    typedef enum logic [1:0] {
        KIND_ACCESS = 2'd0,
        KIND_POLL   = 2'd1,
        KIND_TERM   = 2'd2,
        KIND_TERM2  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_CRC   = 2'd2,
        ST_ECHO  = 2'd3
    } state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;   // first bit to send at the MSB
        logic [LEN_W-1:0]   len;    // bits to send, start bit included
    } frame_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/cft_frame_pack.sv
module cft_frame_pack
    import cft_pkg::*;
(
    input  logic [1:0]        kind,
    input  logic [ID_W-1:0]   id,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output frame_t            frame
);

    logic [DATA_W-1:0] data_ord;
    logic [ADDR_W-1:0] addr_adj;
    logic              size_bit;
    logic [LEN_W-1:0]  nbytes;
    kind_e             kind_q;

    // byte 0 of the write data is sent first
    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_bytes
        assign data_ord[DATA_W-1-8*g -: 8] = wdata[8*g +: 8];
    end

    assign kind_q = kind_e'(kind);

    always_comb begin
        unique case (size)
            2'd0: begin
                addr_adj = addr;
                size_bit = 1'b0;
                nbytes   = LEN_W'(1);
            end
            2'd1: begin
                addr_adj = {addr[ADDR_W-1:1], 1'b0};
                size_bit = 1'b1;
                nbytes   = LEN_W'(2);
            end
            default: begin
                addr_adj = {addr[ADDR_W-1:2], 2'b01};
                size_bit = 1'b1;
                nbytes   = LEN_W'(4);
            end
        endcase
    end

    always_comb begin
        unique case (kind_q)
            KIND_ACCESS: begin
                frame.bits = {1'b1, id, OPC_ACCESS, ~write, addr_adj, size_bit, data_ord};
                frame.len  = LEN_W'(HDR_LEN) + (write ? (nbytes << 3) : '0);
            end
            KIND_POLL: begin
                frame.bits = {1'b1, id, OPC_POLL, {(FRAME_W-1-ID_W-OPC_W){1'b0}}};
                frame.len  = LEN_W'(1 + ID_W + OPC_W);
            end
            default: begin
                frame.bits = {1'b1, id, OPC_TERM, {(FRAME_W-1-ID_W-TOPC_W){1'b0}}};
                frame.len  = LEN_W'(1 + ID_W + TOPC_W);
            end
        endcase
    end

endmodule

// File: rtl/cft_sclk_gen.sv
module cft_sclk_gen #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,       // a frame occupies the next cycle
    input  logic start,     // first slot begins next cycle
    output logic sclk,
    output logic slot_end   // last cycle of a bit slot
);

    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b1;
        end else if (!run) begin
            cnt  <= '0;
            sclk <= 1'b1;
        end else if (start) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (cnt == CNT_LAST) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    assign slot_end = sclk && (cnt == CNT_LAST);

    // R3
    parked_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> sclk);

    // R3
    slot_open_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && run) |=> !sclk);

endmodule

// File: rtl/cft_shift_fsm.sv
module cft_shift_fsm
    import cft_pkg::*;
#(
    parameter int ECHO_SLOTS = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  frame_t frame_in,
    input  logic   slot_end,
    output logic   req_ready,
    output logic   accept,
    output logic   run,
    output logic   sdo,
    output logic   sdo_oe,
    output logic   done
);

    localparam int MAXC = (FRAME_W > ECHO_SLOTS) ? FRAME_W : ECHO_SLOTS;
    localparam int BC_W = $clog2(MAXC + 1);

    state_e             state, state_nx;
    logic [FRAME_W-1:0] shreg;
    logic [CRC_W-1:0]   crc;
    logic [BC_W-1:0]    bit_cnt;
    logic               last_slot;

    assign last_slot = slot_end && (bit_cnt == BC_W'(1));
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign run       = (state_nx != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_FRAME;
            ST_FRAME: if (last_slot) state_nx = ST_CRC;
            ST_CRC:   if (last_slot) state_nx = ST_ECHO;
            ST_ECHO:  if (last_slot) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // shift register, check bits and slot counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            crc     <= '0;
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    shreg   <= frame_in.bits;
                    crc     <= '0;
                    bit_cnt <= BC_W'(frame_in.len);
                end
                ST_FRAME: if (slot_end) begin
                    crc     <= crc_step(crc, shreg[FRAME_W-1]);
                    shreg   <= shreg << 1;
                    bit_cnt <= last_slot ? BC_W'(CRC_W) : bit_cnt - 1'b1;
                end
                ST_CRC: if (slot_end) begin
                    crc     <= crc << 1;
                    bit_cnt <= last_slot ? BC_W'(ECHO_SLOTS) : bit_cnt - 1'b1;
                end
                ST_ECHO: if (slot_end) begin
                    bit_cnt <= bit_cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (state == ST_ECHO) && last_slot;
    end

    // line outputs (active low data)
    always_comb begin
        sdo    = 1'b1;
        sdo_oe = 1'b1;
        unique case (state)
            ST_IDLE:  sdo_oe = 1'b0;
            ST_FRAME: sdo    = ~shreg[FRAME_W-1];
            ST_CRC:   sdo    = ~crc[CRC_W-1];
            ST_ECHO:  sdo    = 1'b1;
            default:  sdo_oe = 1'b0;
        endcase
    end

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (sdo_oe && !sdo));

    // R11
    echo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ECHO) |-> (sdo && sdo_oe));

    // R10
    crc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CRC) |-> (bit_cnt != '0 && bit_cnt <= BC_W'(CRC_W)));

    // R13
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !last_slot) |=> (state != ST_IDLE));

endmodule

// File: rtl/cmdframe_tx.sv
module cmdframe_tx
    import cft_pkg::*;
#(
    parameter int CLK_DIV    = 2,
    parameter int ECHO_SLOTS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_kind,
    input  logic [1:0]  req_id,
    input  logic        req_write,
    input  logic [20:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        sclk,
    output logic        sdo,
    output logic        sdo_oe,
    output logic        done
);

    frame_t frame;
    logic   accept;
    logic   run;
    logic   slot_end;

    cft_frame_pack u_pack (
        .kind  (req_kind),
        .id    (req_id),
        .write (req_write),
        .addr  (req_addr),
        .size  (req_size),
        .wdata (req_wdata),
        .frame (frame)
    );

    cft_sclk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .start    (accept),
        .sclk     (sclk),
        .slot_end (slot_end)
    );

    cft_shift_fsm #(.ECHO_SLOTS(ECHO_SLOTS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .frame_in  (frame),
        .slot_end  (slot_end),
        .req_ready (req_ready),
        .accept    (accept),
        .run       (run),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .done      (done)
    );

    // R3
    data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo));

    // R2
    released_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> sdo);

    // R11
    release_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sdo_oe && sclk));

endmodule

// File: tb/sim_cmdframe_tx.sv
module sim_cmdframe_tx;

    localparam int DIV  = 2;
    localparam int ECHO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_id = '0;
    logic        req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        sclk, sdo, sdo_oe, done;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    cmdframe_tx #(.CLK_DIV(DIV), .ECHO_SLOTS(ECHO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_id(req_id), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at %0t: actual=%0d expected=%0d", tag, what, $time, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit    busy_m = 0;
    bit    done_m = 0;
    int    n_m = 0;
    bit    eq[$];
    string tq[$];

    function automatic void put(input longint v, input int nb, input string tag);
        for (int i = nb - 1; i >= 0; i--) begin
            eq.push_back(v[i]);
            tq.push_back(tag);
        end
    endfunction

    function automatic void build_frame();
        logic [3:0] c;
        int a;
        int nb;
        bit sb;
        eq.delete();
        tq.delete();
        put(1, 1, "R4");
        if (req_kind == 2'd0) begin
            put(req_id, 2, "R5");
            put(3'b100, 3, "R5");
            put(req_write ? 0 : 1, 1, "R5");
            a = int'(req_addr);
            if (req_size == 2'd0) begin sb = 0; nb = 1; end
            else if (req_size == 2'd1) begin a = a & ~1; sb = 1; nb = 2; end
            else begin a = (a & ~3) | 1; sb = 1; nb = 4; end
            put(a >> 2, 19, "R5");
            put(a & 3, 2, "R6");
            put(sb, 1, "R6");
            if (req_write)
                for (int k = 0; k < nb; k++) put((req_wdata >> (8 * k)) & 8'hff, 8, "R7");
        end else if (req_kind == 2'd1) begin
            put(req_id, 2, "R8");
            put(3'b010, 3, "R8");
        end else begin
            put(req_id, 2, "R9");
            put(6'h3f, 6, "R9");
        end
        c = 4'b0;
        foreach (eq[i]) begin
            bit fb;
            fb = eq[i] ^ c[3];
            c = {c[2:0], 1'b0};
            if (fb) c = c ^ 4'b0011;
        end
        put(c, 4, "R10");
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_m = 0;
            done_m = 0;
            n_m    = 0;
        end else begin
            done_m = 0;
            if (!busy_m) begin
                if (req_valid) begin
                    build_frame();
                    busy_m = 1;
                    n_m    = 0;
                end
            end else begin
                n_m++;
                if (n_m == (eq.size() + ECHO) * 2 * DIV) begin
                    busy_m = 0;
                    done_m = 1;
                end
            end
        end
    end

    // compare half a cycle after each edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy_m) begin
                int slot;
                bit es_clk;
                bit es_do;
                string tag;
                slot   = n_m / (2 * DIV);
                es_clk = (n_m % (2 * DIV)) >= DIV;
                if (slot < eq.size()) begin
                    es_do = ~eq[slot];
                    tag   = tq[slot];
                end else begin
                    es_do = 1'b1;
                    tag   = "R11";
                end
                chk(sclk == es_clk, "R3", "sclk", sclk, es_clk);
                chk(sdo == es_do, tag, "sdo", sdo, es_do);
                chk(sdo_oe == 1'b1, "R11", "sdo_oe", sdo_oe, 1);
                chk(req_ready == 1'b0, "R13", "req_ready busy", req_ready, 0);
                chk(done == 1'b0, "R1", "done busy", done, 0);
            end else begin
                chk(sclk == 1'b1, "R3", "sclk idle", sclk, 1);
                chk(sdo == 1'b1, "R2", "sdo idle", sdo, 1);
                chk(sdo_oe == 1'b0, "R11", "sdo_oe idle", sdo_oe, 0);
                chk(req_ready == 1'b1, "R1", "req_ready idle", req_ready, 1);
                chk(done == done_m, "R1", "done", done, done_m);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input logic [1:0] k, input logic [1:0] id, input logic wr,
                         input logic [20:0] ad, input logic [1:0] sz, input logic [31:0] wd);
        req_kind  = k;
        req_id    = id;
        req_write = wr;
        req_addr  = ad;
        req_size  = sz;
        req_wdata = wd;
        req_valid = 1'b1;
    endtask

    task automatic send(input logic [1:0] k, input logic [1:0] id, input logic wr,
                        input logic [20:0] ad, input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        drive(k, id, wr, ad, sz, wd);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset values
        chk(sclk == 1'b1, "R12", "sclk reset", sclk, 1);
        chk(sdo == 1'b1, "R12", "sdo reset", sdo, 1);
        chk(sdo_oe == 1'b0, "R12", "sdo_oe reset", sdo_oe, 0);
        chk(done == 1'b0, "R12", "done reset", done, 0);
        chk(req_ready == 1'b1, "R12", "req_ready reset", req_ready, 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        send(2'd0, 2'd1, 1'b0, 21'h0A5A5B, 2'd0, 32'h0);          // read 1B (R5, R6)
        send(2'd0, 2'd2, 1'b0, 21'h1FFFFF, 2'd1, 32'h0);          // read 2B, odd address (R6)
        send(2'd0, 2'd3, 1'b0, 21'h123456, 2'd2, 32'h0);          // read 4B (R6)
        send(2'd0, 2'd0, 1'b1, 21'h000003, 2'd0, 32'h000000C3);   // write 1B (R7)
        send(2'd0, 2'd1, 1'b1, 21'h0F0F0F, 2'd1, 32'h00005AA5);   // write 2B (R7)
        send(2'd0, 2'd2, 1'b1, 21'h155555, 2'd3, 32'hDEADBEEF);   // write 4B, size 3 (R6, R7)
        send(2'd1, 2'd3, 1'b0, 21'h0, 2'd0, 32'h0);               // poll (R8)
        send(2'd2, 2'd1, 1'b0, 21'h0, 2'd0, 32'h0);               // terminate (R9)
        send(2'd3, 2'd2, 1'b1, 21'h1, 2'd2, 32'hFFFFFFFF);        // terminate alias (R9)

        // R13: junk request while busy, then held so it is taken at done (R1)
        @(negedge clk);
        drive(2'd0, 2'd1, 1'b1, 21'h000100, 2'd2, 32'h01020304);
        @(negedge clk);
        @(negedge clk);
        drive(2'd1, 2'd0, 1'b0, 21'h0, 2'd0, 32'h0);
        repeat (40) begin
            @(negedge clk);
            req_id   = req_id + 2'd1;
            req_kind = req_kind ^ 2'd3;
        end
        drive(2'd2, 2'd3, 1'b0, 21'h0, 2'd0, 32'h0);
        while (!req_ready) @(negedge clk);   // back-to-back take at done
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);

        repeat (6) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule